// File: doc/BRIEF.md
# Per-Slot TDM Pin Direction Controller

This block decides, for each of 16 bidirectional serial data pins, whether the pin is driven during the current time slot. A table of enable words, one 16-bit word per time slot and one bit per stream, is filled through a simple write port. A timing block outside this unit supplies the index of the upcoming slot and a one-cycle pulse at each slot boundary. The controller reads the upcoming slot's word ahead of time and makes it active at the boundary. The active word is then gated with a global output enable to form the tristate enables.

When the global enable is low, every tristate enable drops at once, without waiting for a clock edge. The internal transmit streams are then fed straight back to the internal receive streams, so the external bus is disconnected and a loopback path is formed. When the global enable is high, the receive streams always come from the pins, including pins that this block is driving, so driven data is sampled back in. The number of table words in use depends on the bus rate: 32, 64 or 128 words per frame.

Top module: `tdm_oe_ctrl`

## Requirements
- R1: After reset, `pad_oe` is all zero. The table is cleared to zero over the MAX_SLOTS (128) cycles that follow reset release, so any slot fetched after that yields an all-zero word until software writes it.
- R2: A table write presented while the post-reset clear is still running is dropped, and that word still reads zero afterwards.
- R3: Bit i of `pad_oe` is high only when `gen_oe` is high and bit i of the active slot word is high.
- R4: The word at table address `slot_next`, sampled on the clock edge before the edge on which `slot_adv` is high, becomes the active word after that `slot_adv` edge. It stays unchanged until the next `slot_adv`, even when `slot_next` changes or other words are written.
- R5: `rate_sel` selects how many table words are used. Code 0 (2.048 Mbps) uses only address bits [4:0] of `slot_next` (32 words). Code 1 (4.096 Mbps) uses bits [5:0] (64 words). Codes 2 and 3 (8.192 Mbps) use bits [6:0] (128 words).
- R6: When `gen_oe` goes low, `pad_oe` goes to zero with no clock edge. When `gen_oe` returns high, the enables of the active word come back, again with no clock edge.
- R7: While `gen_oe` is low, `rx_data` equals `tx_data`, and `pad_in` has no effect on it.
- R8: While `gen_oe` is high, `rx_data` equals `pad_in` for all 16 streams, whether or not a stream is driven.
- R9: `pad_out` always equals `tx_data`.
- R10: A write to the same address that a fetch reads on the same edge does not affect that fetch, which yields the old word. The next fetch of that slot yields the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 2 | Bus rate code: 0 = 32 slots, 1 = 64 slots, 2 or 3 = 128 slots |
| gen_oe | input | 1 | Global output enable; low selects internal loopback |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 7 | Table word address |
| wr_data | input | 16 | Enable word, one bit per stream |
| slot_next | input | 7 | Index of the upcoming time slot |
| slot_adv | input | 1 | One-cycle pulse at a slot boundary |
| tx_data | input | 16 | Internal transmit streams |
| rx_data | output | 16 | Internal receive streams |
| pad_in | input | 16 | Data sampled from the pins |
| pad_out | output | 16 | Data to the pin drivers |
| pad_oe | output | 16 | Tristate enables, high = drive |

## Verification
Two functions can land in the same cycle: a software write to the table, and the look-ahead read of that same word for the upcoming slot. The bench provokes this by presenting the write and the new slot index on the same clock edge, then pulsing the slot advance. It judges the result by expecting the old word on `pad_oe` after that advance, and the new word only after a second fetch of the same slot. A second overlap, the global enable dropping while a slot word is active, is provoked between clock edges. It is judged by the enables falling and recovering with no edge in between.

// File: rtl/tdm_oe_pkg.sv
package tdm_oe_pkg;

  typedef enum logic [1:0] {
    RATE_2M   = 2'd0,
    RATE_4M   = 2'd1,
    RATE_8M   = 2'd2,
    RATE_8M_B = 2'd3
  } tdm_rate_e;

endpackage

// File: rtl/tdm_oe_table.sv
module tdm_oe_table #(
  parameter int NUM_STREAMS = 16,
  parameter int MAX_SLOTS   = 128,
  localparam int ADDR_W     = $clog2(MAX_SLOTS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [NUM_STREAMS-1:0] wr_data,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [NUM_STREAMS-1:0] rd_q,
  output logic                   blank
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(MAX_SLOTS - 1);

  logic [NUM_STREAMS-1:0] mem [MAX_SLOTS];
  logic                   clr_busy;
  logic                   clr_busy_d;
  logic [ADDR_W-1:0]      clr_cnt;

  logic                   we;
  logic [ADDR_W-1:0]      wa;
  logic [NUM_STREAMS-1:0] wd;

  // post-reset sweep owns the write port; user writes are dropped meanwhile
  always_ff @(posedge clk) begin
    if (rst) begin
      clr_busy   <= 1'b1;
      clr_busy_d <= 1'b1;
      clr_cnt    <= '0;
    end else begin
      clr_busy_d <= clr_busy;
      if (clr_busy) begin
        clr_cnt <= clr_cnt + 1'b1;
        if (clr_cnt == LAST_ADDR) clr_busy <= 1'b0;
      end
    end
  end

  always_comb begin
    we = clr_busy | wr_en;
    wa = clr_busy ? clr_cnt : wr_addr;
    wd = clr_busy ? '0 : wr_data;
  end

  // single write port, registered read-first read port
  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd_q <= mem[rd_addr];
  end

  assign blank = clr_busy | clr_busy_d;

  assert_clear_step_R1: assert property (@(posedge clk) disable iff (rst)
    clr_busy |=> (!clr_busy || clr_cnt == ADDR_W'($past(clr_cnt) + 1'b1)));

endmodule

// File: rtl/tdm_oe_fetch.sv
module tdm_oe_fetch
  import tdm_oe_pkg::*;
#(
  parameter int NUM_STREAMS = 16,
  parameter int MAX_SLOTS   = 128,
  localparam int ADDR_W     = $clog2(MAX_SLOTS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             rate_sel,
  input  logic [ADDR_W-1:0]      slot_next,
  input  logic                   slot_adv,
  input  logic [NUM_STREAMS-1:0] rd_q,
  input  logic                   blank,
  output logic [ADDR_W-1:0]      rd_addr,
  output logic [NUM_STREAMS-1:0] cur_word
);

  localparam logic [ADDR_W-1:0] MASK_QTR  = ADDR_W'(MAX_SLOTS / 4 - 1);
  localparam logic [ADDR_W-1:0] MASK_HALF = ADDR_W'(MAX_SLOTS / 2 - 1);
  localparam logic [ADDR_W-1:0] MASK_FULL = ADDR_W'(MAX_SLOTS - 1);

  tdm_rate_e rate;
  logic [ADDR_W-1:0] mask;

  always_comb begin
    rate = tdm_rate_e'(rate_sel);
    unique case (rate)
      RATE_2M: mask = MASK_QTR;
      RATE_4M: mask = MASK_HALF;
      default: mask = MASK_FULL;
    endcase
    rd_addr = slot_next & mask;
  end

  // word read on the previous edge becomes active at the slot boundary
  always_ff @(posedge clk) begin
    if (rst)           cur_word <= '0;
    else if (slot_adv) cur_word <= blank ? '0 : rd_q;
  end

  assert_word_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !slot_adv |=> $stable(cur_word));

  assert_rate_qtr_R5: assert property (@(posedge clk) disable iff (rst)
    (rate_sel == 2'd0) |-> (rd_addr < ADDR_W'(MAX_SLOTS / 4)));

  assert_rate_half_R5: assert property (@(posedge clk) disable iff (rst)
    (rate_sel == 2'd1) |-> (rd_addr < ADDR_W'(MAX_SLOTS / 2)));

endmodule

// File: rtl/tdm_oe_route.sv
module tdm_oe_route #(
  parameter int NUM_STREAMS = 16
) (
  input  logic                   gen_oe,
  input  logic [NUM_STREAMS-1:0] cur_word,
  input  logic [NUM_STREAMS-1:0] tx_data,
  input  logic [NUM_STREAMS-1:0] pad_in,
  output logic [NUM_STREAMS-1:0] pad_out,
  output logic [NUM_STREAMS-1:0] pad_oe,
  output logic [NUM_STREAMS-1:0] rx_data
);

  // global enable acts without a clock so drivers release immediately
  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
    assign pad_oe[s]  = gen_oe & cur_word[s];
    assign pad_out[s] = tx_data[s];
    assign rx_data[s] = gen_oe ? pad_in[s] : tx_data[s];
  end

endmodule

// File: rtl/tdm_oe_ctrl.sv
module tdm_oe_ctrl #(
  parameter int NUM_STREAMS = 16,
  parameter int MAX_SLOTS   = 128,
  localparam int ADDR_W     = $clog2(MAX_SLOTS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             rate_sel,
  input  logic                   gen_oe,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [NUM_STREAMS-1:0] wr_data,
  input  logic [ADDR_W-1:0]      slot_next,
  input  logic                   slot_adv,
  input  logic [NUM_STREAMS-1:0] tx_data,
  output logic [NUM_STREAMS-1:0] rx_data,
  input  logic [NUM_STREAMS-1:0] pad_in,
  output logic [NUM_STREAMS-1:0] pad_out,
  output logic [NUM_STREAMS-1:0] pad_oe
);

  logic [ADDR_W-1:0]      rd_addr;
  logic [NUM_STREAMS-1:0] rd_q;
  logic [NUM_STREAMS-1:0] cur_word;
  logic                   tbl_blank;

  tdm_oe_table #(.NUM_STREAMS(NUM_STREAMS), .MAX_SLOTS(MAX_SLOTS)) u_table (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_q    (rd_q),
    .blank   (tbl_blank)
  );

  tdm_oe_fetch #(.NUM_STREAMS(NUM_STREAMS), .MAX_SLOTS(MAX_SLOTS)) u_fetch (
    .clk       (clk),
    .rst       (rst),
    .rate_sel  (rate_sel),
    .slot_next (slot_next),
    .slot_adv  (slot_adv),
    .rd_q      (rd_q),
    .blank     (tbl_blank),
    .rd_addr   (rd_addr),
    .cur_word  (cur_word)
  );

  tdm_oe_route #(.NUM_STREAMS(NUM_STREAMS)) u_route (
    .gen_oe   (gen_oe),
    .cur_word (cur_word),
    .tx_data  (tx_data),
    .pad_in   (pad_in),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .rx_data  (rx_data)
  );

  assert_clear_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    tbl_blank |-> (pad_oe == '0));

  assert_oe_subset_R3: assert property (@(posedge clk) disable iff (rst)
    (pad_oe & ~cur_word) == '0);

endmodule

// File: tb/tdm_oe_ctrl_tb.sv
module tdm_oe_ctrl_tb;

  localparam int NS = 16;
  localparam int MS = 128;
  localparam int AW = 7;
  localparam int NVEC = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    rate_sel = 2'd2;
  logic          gen_oe = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [NS-1:0] wr_data = '0;
  logic [AW-1:0] slot_next = '0;
  logic          slot_adv = 1'b0;
  logic [NS-1:0] tx_data = '0;
  logic [NS-1:0] pad_in = '0;
  logic [NS-1:0] rx_data, pad_out, pad_oe;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [NS-1:0] model [MS];

  always #5 clk = ~clk;

  tdm_oe_ctrl u_dut (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .gen_oe(gen_oe),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .slot_next(slot_next), .slot_adv(slot_adv),
    .tx_data(tx_data), .rx_data(rx_data), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // rate, slot, gen_oe, tx, pins
  localparam logic [41:0] VEC [0:NVEC-1] = '{
    {2'd0, 7'd37,  1'b1, 16'h1234, 16'hBEEF},
    {2'd0, 7'd5,   1'b1, 16'hFFFF, 16'h0000},
    {2'd1, 7'd100, 1'b1, 16'hA0A0, 16'h5A5A},
    {2'd1, 7'd36,  1'b0, 16'h0F0F, 16'hF0F0},
    {2'd2, 7'd100, 1'b1, 16'h8001, 16'h7FFE},
    {2'd3, 7'd127, 1'b1, 16'h0000, 16'hFFFF},
    {2'd2, 7'd0,   1'b0, 16'hC3C3, 16'h3C3C},
    {2'd0, 7'd127, 1'b1, 16'h1111, 16'h2222},
    {2'd1, 7'd63,  1'b0, 16'hDEAD, 16'hBEEF},
    {2'd3, 7'd64,  1'b1, 16'h4321, 16'h8765}
  };

  function automatic logic [NS-1:0] pat(input int a);
    return 16'hA5C3 ^ NS'(a * 16'h0111);
  endfunction

  function automatic int eff_addr(input logic [1:0] r, input int s);
    if (r == 2'd0) return s % 32;
    if (r == 2'd1) return s % 64;
    return s % 128;
  endfunction

  task automatic check(input string tag, input logic [NS-1:0] act, input logic [NS-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [NS-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic fetch(input int s);
    @(negedge clk);
    slot_next = AW'(s);
    @(negedge clk);
    slot_adv = 1'b1;
    @(negedge clk);
    slot_adv = 1'b0;
  endtask

  initial begin
    int wd;
    wd = 0;
    while (!done && wd < 100000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", wd);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [NS-1:0] w;
    repeat (3) @(negedge clk);
    check("R1 oe in reset", pad_oe, '0);
    rst = 1'b0;
    // R2: write during the clear sweep, after the sweep passed address 3
    repeat (10) @(negedge clk);
    wr(3, 16'hFFFF);
    repeat (140) @(negedge clk);
    check("R1 oe after clear", pad_oe, '0);
    fetch(3);
    check("R2 dropped write", pad_oe, '0);
    fetch(77);
    check("R1 cleared word", pad_oe, '0);

    for (int a = 0; a < MS; a++) begin
      wr(a, pat(a));
      model[a] = pat(a);
    end

    // vector walk: R3 R5 R7 R8 R9
    for (int i = 0; i < NVEC; i++) begin
      logic [1:0]  r;
      int          s;
      logic        g;
      logic [NS-1:0] t, p;
      {r, s, g, t, p} = {VEC[i][41:40], 25'd0, VEC[i][39:33], VEC[i][32], VEC[i][31:16], VEC[i][15:0]};
      rate_sel = r; gen_oe = g; tx_data = t; pad_in = p;
      fetch(s);
      w = model[eff_addr(r, s)];
      check("R3/R5 pad_oe", pad_oe, g ? w : '0);
      check(g ? "R8 rx from pins" : "R7 loopback", rx_data, g ? p : t);
      check("R9 pad_out", pad_out, t);
    end

    // R6: enable drops and returns without a clock edge
    rate_sel = 2'd2; gen_oe = 1'b1;
    fetch(10);
    check("R4 fetched word", pad_oe, model[10]);
    #1 gen_oe = 1'b0;
    #1 check("R6 async off", pad_oe, '0);
    gen_oe = 1'b1;
    #1 check("R6 async on", pad_oe, model[10]);

    // R4: no advance -> active word holds despite slot change and other write
    @(negedge clk);
    slot_next = 7'd20;
    wr(10, 16'h0000);
    model[10] = 16'h0000;
    repeat (3) @(negedge clk);
    check("R4 hold without advance", pad_oe, pat(10));

    // R10: write and read of slot 9 on the same edge
    @(negedge clk);
    slot_next = 7'd9; wr_en = 1'b1; wr_addr = 7'd9; wr_data = 16'h00FF;
    @(negedge clk);
    wr_en = 1'b0; slot_adv = 1'b1;
    @(negedge clk);
    slot_adv = 1'b0;
    check("R10 old word on collision", pad_oe, pat(9));
    fetch(9);
    check("R10 new word next fetch", pad_oe, 16'h00FF);

    // R7: pad_in ignored in loopback
    gen_oe = 1'b0; tx_data = 16'h6B6B; pad_in = 16'h0000;
    #1 check("R7 loopback pins ignored", rx_data, 16'h6B6B);
    pad_in = 16'hFFFF;
    #1 check("R7 loopback pins ignored 2", rx_data, 16'h6B6B);

    // R1: reset again mid-run clears enables
    gen_oe = 1'b1;
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R1 reset clears oe", pad_oe, '0);
    rst = 1'b0;
    repeat (140) @(negedge clk);
    fetch(9);
    check("R1 table cleared again", pad_oe, '0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule